// File: doc/BRIEF.md
# Mailbox abort completion checker

This block sits beside a multi-mailbox CAN transmit controller and watches what happens after software asks for a pending transmission to be cancelled. When an abort request arrives for a mailbox index, the block masks that mailbox's interrupt. It then waits for a window whose length grows with the index, and reads three status bits of that mailbox at the end of the window: the cancel-request bit, the transmit-acknowledge bit and the abort-acknowledge bit.

The block sorts the result into one of three classes. If the cancel request is still outstanding, nothing has gone wrong yet. If the request has cleared and either acknowledge is set, the abort finished normally, and the usual interrupt fires once the mask is lifted. If the request has cleared and both acknowledges are low, the abort finished silently. The block flags this as a lost abort and names the mailbox, so that recovery code can run the completion path itself. That path does not touch the abort-acknowledge bit.

The block never touches the bit engine or message storage. It only reads status vectors and drives a per-mailbox interrupt mask, a result code and strobes. It handles one check at a time.

Top module: `tx_abort_watch`

## Requirements
- R1: A synchronous active-high reset, including one in the middle of a check, returns the block to idle. After it, busy, done, the unmask strobe and the lost flag are low, the outcome reads 00, lost_idx reads 0 and every interrupt mask bit is 0.
- R2: A request seen on a clock edge while idle is accepted. From the next cycle, busy is high and irq_mask has exactly the bit whose position equals the requested index set.
- R3: The status bits are sampled on the clock edge that falls 2*idx+3 edges after the accepting edge. Done is high in the cycle that follows that edge and in no earlier cycle.
- R4: If the selected cancel-request bit is 1 at the sample edge, the outcome is 00 (still pending), whatever the acknowledge bits are.
- R5: If the selected cancel-request bit is 0 and at least one of the selected transmit-acknowledge or abort-acknowledge bits is 1, the outcome is 01 (normal completion) and lost_flag stays low.
- R6: If the selected cancel-request bit and both selected acknowledge bits are 0, the outcome is 10 (lost abort). lost_flag is high and lost_idx equals the mailbox index.
- R7: Done, the outcome code and the unmask strobe are valid together for exactly one cycle. Outside that cycle the outcome reads 00 and lost_idx reads 0.
- R8: The interrupt mask bit stays set through the report cycle. It clears, together with busy, on the edge that ends that cycle.
- R9: A request that arrives while busy is ignored. The mask, the reported index and the timing of the check in progress do not change.
- R10: Only the selected mailbox's bits at the sample edge count. Values seen earlier in the window, and the bits of every other mailbox, have no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| abort_req | input | 1 | Abort request strobe from software |
| abort_idx | input | 5 | Mailbox index of the abort request |
| req_bits | input | 32 | Cancel-request status, one bit per mailbox |
| txack_bits | input | 32 | Transmit-acknowledge status, one bit per mailbox |
| abtack_bits | input | 32 | Abort-acknowledge status, one bit per mailbox |
| busy | output | 1 | High while a check is in progress |
| irq_mask | output | 32 | Interrupt mask, one bit per mailbox |
| done | output | 1 | One-cycle strobe: the outcome is valid |
| outcome | output | 2 | 00 pending, 01 normal completion, 10 lost abort |
| lost_flag | output | 1 | One-cycle lost-abort indication |
| lost_idx | output | 5 | Mailbox index that goes with lost_flag |
| unmask_stb | output | 1 | One-cycle strobe to re-enable the interrupt |

## Verification
Most checks use random mailbox indices with random status vectors and random values of the three sampled bits. This separates the three outcome classes and shows that the window length follows the index. Directed cases at index 0 and index 31 probe the shortest and longest windows. Further directed cases hold a misleading pattern (already cleared, no acknowledge) in the selected bits during the window and change them only at the sample edge, which tells sampling at the window end apart from sampling early. Other cases present a second request during a check, or assert reset in the middle of a window, to show that the check in progress is left alone and that reset clears everything.

// File: rtl/tx_abort_watch_pkg.sv
package tx_abort_watch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MASK,
    ST_WAIT,
    ST_SAMPLE,
    ST_REPORT
  } watch_state_e;

  typedef enum logic [1:0] {
    OUT_PENDING = 2'b00,
    OUT_NORMAL  = 2'b01,
    OUT_LOST    = 2'b10
  } outcome_e;

  // Check window length in clocks for a mailbox index.
  function automatic int window_len(int idx, int mul, int ofs);
    return idx * mul + ofs;
  endfunction

  // Outcome class from the three sampled bits of one mailbox.
  function automatic outcome_e classify(logic req_set, logic tx_ack, logic ab_ack);
    if (req_set) return OUT_PENDING;
    if (tx_ack || ab_ack) return OUT_NORMAL;
    return OUT_LOST;
  endfunction

endpackage

// File: rtl/tx_abort_win_timer.sv
module tx_abort_win_timer import tx_abort_watch_pkg::*; #(
  parameter int IDX_W   = 5,
  parameter int CNT_W   = 7,
  parameter int WIN_MUL = 2,
  parameter int WIN_OFS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] load_idx,
  input  logic             run,
  output logic             near_end,
  output logic             at_end
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CNT_W'(window_len(int'(load_idx), WIN_MUL, WIN_OFS));
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign near_end = (cnt_q == CNT_W'(2));
  assign at_end   = (cnt_q == CNT_W'(1));

  // R3
  count_falls_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !load && (cnt_q != '0)) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/tx_abort_outcome_cls.sv
module tx_abort_outcome_cls import tx_abort_watch_pkg::*; #(
  parameter int NUM_MB = 32,
  parameter int IDX_W  = 5
) (
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic [NUM_MB-1:0] req_bits,
  input  logic [NUM_MB-1:0] txack_bits,
  input  logic [NUM_MB-1:0] abtack_bits,
  output logic              sel_req,
  output logic              sel_ack,
  output outcome_e          code
);

  logic sel_tx;
  logic sel_ab;

  always_comb begin
    sel_req = req_bits[sel_idx];
    sel_tx  = txack_bits[sel_idx];
    sel_ab  = abtack_bits[sel_idx];
    sel_ack = sel_tx | sel_ab;
    code    = classify(sel_req, sel_tx, sel_ab);
  end

endmodule

// File: rtl/tx_abort_irq_mask.sv
module tx_abort_irq_mask #(
  parameter int NUM_MB = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic              clr_en,
  output logic [NUM_MB-1:0] mask
);

  for (genvar i = 0; i < NUM_MB; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr_en) begin
        mask[i] <= 1'b0;
      end else if (set_en && (set_idx == IDX_W'(i))) begin
        mask[i] <= 1'b1;
      end
    end
  end

  // R2
  mask_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mask));

endmodule

// File: rtl/tx_abort_watch.sv
module tx_abort_watch import tx_abort_watch_pkg::*; #(
  parameter int NUM_MB  = 32,
  parameter int WIN_MUL = 2,
  parameter int WIN_OFS = 3,
  localparam int IDX_W  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort_req,
  input  logic [IDX_W-1:0]  abort_idx,
  input  logic [NUM_MB-1:0] req_bits,
  input  logic [NUM_MB-1:0] txack_bits,
  input  logic [NUM_MB-1:0] abtack_bits,
  output logic              busy,
  output logic [NUM_MB-1:0] irq_mask,
  output logic              done,
  output logic [1:0]        outcome,
  output logic              lost_flag,
  output logic [IDX_W-1:0]  lost_idx,
  output logic              unmask_stb
);

  localparam int MAX_WIN = WIN_MUL * (NUM_MB - 1) + WIN_OFS;
  localparam int CNT_W   = $clog2(MAX_WIN + 1);

  watch_state_e     state_q;
  logic [IDX_W-1:0] idx_q;
  outcome_e         code_q;

  // Named internal events for the assertions.
  logic     accept_ev;
  logic     timer_run;
  logic     tmr_near_end;
  logic     tmr_at_end;
  logic     report_ev;
  logic     cls_req;
  logic     cls_ack;
  outcome_e cls_code;

  assign accept_ev = abort_req && (state_q == ST_IDLE);
  assign timer_run = (state_q == ST_MASK) || (state_q == ST_WAIT) ||
                     (state_q == ST_SAMPLE);
  assign report_ev = (state_q == ST_REPORT);

  tx_abort_win_timer #(
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W),
    .WIN_MUL(WIN_MUL),
    .WIN_OFS(WIN_OFS)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (accept_ev),
    .load_idx(abort_idx),
    .run     (timer_run),
    .near_end(tmr_near_end),
    .at_end  (tmr_at_end)
  );

  tx_abort_outcome_cls #(
    .NUM_MB(NUM_MB),
    .IDX_W (IDX_W)
  ) u_cls (
    .sel_idx    (idx_q),
    .req_bits   (req_bits),
    .txack_bits (txack_bits),
    .abtack_bits(abtack_bits),
    .sel_req    (cls_req),
    .sel_ack    (cls_ack),
    .code       (cls_code)
  );

  tx_abort_irq_mask #(
    .NUM_MB(NUM_MB),
    .IDX_W (IDX_W)
  ) u_mask (
    .clk    (clk),
    .rst    (rst),
    .set_en (accept_ev),
    .set_idx(abort_idx),
    .clr_en (report_ev),
    .mask   (irq_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      code_q  <= OUT_PENDING;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept_ev) begin
            idx_q   <= abort_idx;
            state_q <= ST_MASK;
          end
        end
        ST_MASK:   state_q <= ST_WAIT;
        ST_WAIT: begin
          if (tmr_near_end) state_q <= ST_SAMPLE;
        end
        ST_SAMPLE: begin
          code_q  <= cls_code;
          state_q <= ST_REPORT;
        end
        ST_REPORT: begin
          code_q  <= OUT_PENDING;
          state_q <= ST_IDLE;
        end
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = report_ev;
  assign unmask_stb = report_ev;
  assign outcome    = code_q;
  assign lost_flag  = (code_q == OUT_LOST);
  assign lost_idx   = lost_flag ? idx_q : '0;

  // R2
  accept_masks_chk: assert property (@(posedge clk) disable iff (rst)
    (abort_req && !busy) |=> (busy && irq_mask[$past(abort_idx)]));

  // R3
  sample_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SAMPLE) |-> tmr_at_end);

  // R4
  pending_kept_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_SAMPLE) && cls_req) |=> (done && (outcome == 2'b00)));

  // R6
  lost_needs_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_SAMPLE) && !cls_req && !cls_ack) |=> (lost_flag && done));

  // R7
  report_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !unmask_stb && (outcome == 2'b00)));

  // R8
  release_after_report_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> ((irq_mask == '0) && !busy));

  // R9
  busy_holds_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(irq_mask));

endmodule

// File: tb/tx_abort_watch_test.sv
`timescale 1ns/1ps
module tx_abort_watch_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        abort_req = 1'b0;
  logic [4:0]  abort_idx = '0;
  logic [31:0] req_bits = '0;
  logic [31:0] txack_bits = '0;
  logic [31:0] abtack_bits = '0;
  logic        busy;
  logic [31:0] irq_mask;
  logic        done;
  logic [1:0]  outcome;
  logic        lost_flag;
  logic [4:0]  lost_idx;
  logic        unmask_stb;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tx_abort_watch uut (
    .clk(clk), .rst(rst), .abort_req(abort_req), .abort_idx(abort_idx),
    .req_bits(req_bits), .txack_bits(txack_bits), .abtack_bits(abtack_bits),
    .busy(busy), .irq_mask(irq_mask), .done(done), .outcome(outcome),
    .lost_flag(lost_flag), .lost_idx(lost_idx), .unmask_stb(unmask_stb)
  );

  function automatic int exp_window(int idx);
    return idx + idx + 3;
  endfunction

  function automatic int exp_code(bit rq, bit tx, bit ab);
    if (rq == 1'b1) return 0;
    return (tx | ab) ? 1 : 2;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic noise();
    req_bits    = $urandom;
    txack_bits  = $urandom;
    abtack_bits = $urandom;
  endtask

  task automatic check_idle(string req);
    chk(busy == 1'b0, {req, " busy"}, busy, 0);
    chk(irq_mask == 32'h0, {req, " mask"}, irq_mask, 0);
    chk(done == 1'b0 && unmask_stb == 1'b0, {req, " strobes"}, {done, unmask_stb}, 0);
    chk(outcome == 2'b00 && lost_flag == 1'b0 && lost_idx == 5'd0,
        {req, " outcome"}, {outcome, lost_flag, lost_idx}, 0);
  endtask

  // mislead: hold a cleared, unacknowledged pattern in the window
  task automatic run_abort(int idx, bit rq, bit tx, bit ab, bit poke, bit mislead);
    int w = exp_window(idx);
    int ex = exp_code(rq, tx, ab);
    bit early = 1'b0;
    bit mask_ok = 1'b1;
    @(negedge clk);
    abort_req = 1'b1;
    abort_idx = 5'(idx);
    noise();
    @(negedge clk);
    abort_req = 1'b0;
    chk(busy == 1'b1, "R2 busy after accept", busy, 1);
    chk(irq_mask == (32'h1 << idx), "R2 mask bit", irq_mask, 32'h1 << idx);
    for (int k = 2; k <= w; k++) begin
      @(negedge clk);
      abort_req = 1'b0;
      noise();
      if (poke && k == 2) begin
        abort_req = 1'b1;
        abort_idx = 5'((idx + 7) % 32);
      end
      if (mislead && k < w) begin
        req_bits[idx] = 1'b0;
        txack_bits[idx] = 1'b0;
        abtack_bits[idx] = 1'b0;
      end
      if (k == w) begin
        req_bits[idx] = rq;
        txack_bits[idx] = tx;
        abtack_bits[idx] = ab;
      end
      if (done) early = 1'b1;
      if (irq_mask != (32'h1 << idx)) mask_ok = 1'b0;
    end
    chk(!early, "R3 no done before window end", early, 0);
    chk(mask_ok, "R9 mask unchanged during window", mask_ok, 1);
    @(negedge clk);
    abort_req = 1'b0;
    noise();
    chk(done == 1'b1 && unmask_stb == 1'b1, "R3 R7 done and unmask at window end",
        {done, unmask_stb}, 2'b11);
    if (ex == 0) chk(outcome == 2'd0, "R4 pending outcome", outcome, ex);
    else if (ex == 1) chk(outcome == 2'd1 && !lost_flag, "R5 normal outcome",
                          {lost_flag, outcome}, ex);
    else chk(outcome == 2'd2 && lost_flag && lost_idx == 5'(idx), "R6 lost outcome",
             {lost_flag, outcome, lost_idx}, {1'b1, 2'd2, 5'(idx)});
    if (mislead) chk(int'(outcome) == ex, "R10 sample-edge values only", outcome, ex);
    chk(irq_mask == (32'h1 << idx), "R8 mask held in report", irq_mask, 32'h1 << idx);
    @(negedge clk);
    check_idle("R7 R8 after report");
  endtask

  initial begin
    void'($urandom(32'h5eed_0c4a));
    abort_req = 1'b1;
    abort_idx = 5'd9;
    noise();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    abort_req = 1'b0;
    check_idle("R1 after reset");

    run_abort(0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_abort(31, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    run_abort(31, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    run_abort(0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    run_abort(5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    run_abort(12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    for (int n = 0; n < 40; n++) begin
      run_abort(int'($urandom_range(0, 31)), 1'($urandom), 1'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom));
    end

    // R1: reset in the middle of a check
    @(negedge clk);
    abort_req = 1'b1;
    abort_idx = 5'd20;
    @(negedge clk);
    abort_req = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_idle("R1 reset mid-window");
    repeat (50) @(negedge clk);
    chk(done == 1'b0, "R1 no report after reset", done, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule